// File: doc/BRIEF.md
# Vector integer immediate executor

This block carries out a handful of element-wise vector integer operations against a vector register file. An operation is launched with a one-cycle `start` pulse that carries the two function codes, the mask-enable bit, the three register fields, the element width code, the vector length and the start index. The block then walks element indices from `vstart` up to the end of the operation, one element per cycle. It reads each source element through an element-indexed read port and writes each result through an element-indexed write port. A compare does not write elements one by one. It builds its result mask internally and writes it as a whole register in the final busy cycle.

The supported work is as follows: element copy between registers, compare-equal and compare-not-equal against a sign-extended 5-bit immediate, merge of an immediate under the mask held in register 0, wrap-around immediate addition, and a copy of a whole group of 1, 2, 4 or 8 registers. Illegal uses of an operation are rejected before any write is made, as are function codes outside this set. A pulse on `done` reports the end of every operation, together with two error flags. The register file and the mask register 0 are kept outside the block.

Top module: `vimm_exec`

## Requirements
- R1: funct3=000 with funct6=010111 copies element i of register rs1 into register vd for vstart <= i < vl, leaving other elements untouched; with vm=0 it is illegal.
- R2: funct3=011 with funct6=011000 writes register vd as a whole mask whose bit i is 1 exactly when vstart <= i < vl and element i of vs2 equals the immediate sign-extended to the element width; vm and register 0 do not affect it, and all other bits are 0.
- R3: funct3=011 with funct6=011001 behaves as R2 but sets bit i when the element differs from the immediate.
- R4: funct3=011 with funct6=010111 (merge) writes, for vstart <= i < vl, the sign-extended immediate when element i is active (vm=1, or bit i of register 0 is 1) and element i of vs2 otherwise; vm=0 with vd=0 is illegal.
- R5: funct3=011 with funct6=000000 writes vs2[i] + sign-extended immediate, modulo 2^SEW, into active elements of vd only; vm=0 with vd=0 is illegal.
- R6: The element width code sew selects 8, 16, 32, 64 or 128 bits for codes 0 to 4; a code above the widest supported width, or vl above VLEN/SEW for an element operation, is illegal.
- R7: funct3=011 with funct6=100111 and vm=1 copies NR=rs1+1 registers from vs2.. to vd.., element by element over group indices vstart to NR*VLEN/SEW-1; NR outside {1,2,4,8}, or vstart >= NR*VLEN/SEW, is illegal.
- R8: A whole-group copy with vd equal to vs2 completes with no write, no busy cycle and no error.
- R9: Any other funct3/funct6 pair, including funct6=100111 with vm=0, sets err_unsup and makes no write.
- R10: An accepted start gives max(end-vstart,0)+1 busy cycles followed by a one-cycle done pulse; a rejected or empty operation gives done in the cycle after start with no busy cycle. start is ignored while busy. The flags are valid from done until the next start.
- R11: After reset, busy, done, err_unsup and err_illegal are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| funct3 | input | 3 | Operation class code |
| funct6 | input | 6 | Operation code within the class |
| vm | input | 1 | 1 = unmasked, 0 = masked by register 0 |
| vd | input | 5 | Destination register |
| rs1 | input | 5 | Source register, immediate, or group size minus one |
| vs2 | input | 5 | Source register |
| sew | input | 3 | Element width code |
| vl | input | CNTW | Vector length |
| vstart | input | CNTW | First element index |
| v0_mask | input | VLEN | Contents of register 0 |
| rf_rd_reg | output | 5 | Read register |
| rf_rd_idx | output | EIW | Read element index within register |
| rf_sew | output | 3 | Element width code for both element ports |
| rf_rd_data | input | ELEN | Read element, zero-extended |
| rf_wr_en | output | 1 | Element write strobe |
| rf_wr_reg | output | 5 | Write register |
| rf_wr_idx | output | EIW | Write element index within register |
| rf_wr_data | output | ELEN | Write element |
| mask_wr_en | output | 1 | Whole-register mask write strobe |
| mask_wr_reg | output | 5 | Mask destination register |
| mask_wr_data | output | VLEN | Mask value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| err_unsup | output | 1 | Unsupported function codes |
| err_illegal | output | 1 | Illegal use of a supported operation |

## Verification
Compares are run on byte data in which only some elements hold the negative immediate. This shows sign extension at work and shows that the bits below vstart stay clear. Additions are tried at 8, 64 and 128 bits with operands that carry out of the element, to confirm wrap-around at each width. Masked merge and add are run against an irregular register 0 pattern, which shows whether inactive elements take the source value or are left untouched. Group copies at several sizes and start indices check register stepping, and each illegal or unsupported case is run to confirm that the register file stays unchanged.

// File: rtl/vimm_pkg.sv
package vimm_pkg;
   typedef enum logic [2:0] {
      OP_VMOVE, OP_CMPEQ, OP_CMPNE, OP_MERGE, OP_ADDI, OP_WHOLE
   } vop_e;

   localparam logic [2:0] F3_VV    = 3'b000;
   localparam logic [2:0] F3_VI    = 3'b011;
   localparam logic [5:0] F6_MOVE  = 6'b010111;
   localparam logic [5:0] F6_CMPEQ = 6'b011000;
   localparam logic [5:0] F6_CMPNE = 6'b011001;
   localparam logic [5:0] F6_ADD   = 6'b000000;
   localparam logic [5:0] F6_WHOLE = 6'b100111;
endpackage

// File: rtl/vimm_decode.sv
module vimm_decode
   import vimm_pkg::*;
#(
   parameter int VLEN = 128,
   parameter int ELEN = 128,
   parameter int CNTW = $clog2(VLEN) + 1
) (
   input  logic [2:0]      f3,
   input  logic [5:0]      f6,
   input  logic            vm,
   input  logic [4:0]      vd,
   input  logic [4:0]      rs1,
   input  logic [4:0]      vs2,
   input  logic [2:0]      sew,
   input  logic [CNTW-1:0] vl,
   input  logic [CNTW-1:0] vstart,
   output vop_e            op,
   output logic            unsup,
   output logic            illegal,
   output logic            noop,
   output logic [CNTW-1:0] stop
);
   localparam int MAXSEW = $clog2(ELEN / 8);

   logic [CNTW-1:0] epr;
   logic [CNTW-1:0] evl;
   logic            nr_ok;
   logic            elem_op;

   assign epr   = CNTW'(VLEN >> (3 + int'(sew)));
   assign evl   = CNTW'((VLEN >> (3 + int'(sew))) * (int'(rs1) + 1));
   assign nr_ok = (rs1 == 5'd0) || (rs1 == 5'd1) || (rs1 == 5'd3) || (rs1 == 5'd7);

   always_comb begin
      op      = OP_VMOVE;
      unsup   = 1'b0;
      illegal = 1'b0;
      noop    = 1'b0;
      stop    = vl;
      elem_op = 1'b1;
      if (f3 == F3_VV && f6 == F6_MOVE) begin
         illegal = !vm;
      end else if (f3 == F3_VI) begin
         case (f6)
            F6_CMPEQ: op = OP_CMPEQ;
            F6_CMPNE: op = OP_CMPNE;
            F6_MOVE: begin
               op      = OP_MERGE;
               illegal = !vm && (vd == 5'd0);
            end
            F6_ADD: begin
               op      = OP_ADDI;
               illegal = !vm && (vd == 5'd0);
            end
            F6_WHOLE: begin
               if (vm) begin
                  op      = OP_WHOLE;
                  elem_op = 1'b0;
                  stop    = evl;
                  if (!nr_ok || vstart >= evl) illegal = 1'b1;
                  else if (vd == vs2)          noop    = 1'b1;
               end else begin
                  unsup = 1'b1;
               end
            end
            default: unsup = 1'b1;
         endcase
      end else begin
         unsup = 1'b1;
      end
      if (!unsup && int'(sew) > MAXSEW) illegal = 1'b1;
      if (!unsup && elem_op && vl > epr) illegal = 1'b1;
      if (illegal) noop = 1'b0;
   end
endmodule

// File: rtl/vimm_alu.sv
module vimm_alu
   import vimm_pkg::*;
#(
   parameter int ELEN = 128
) (
   input  vop_e            op,
   input  logic [2:0]      sew,
   input  logic            active,
   input  logic [ELEN-1:0] src,
   input  logic [4:0]      imm,
   output logic            wr,
   output logic [ELEN-1:0] res,
   output logic            hit
);
   localparam int NW = $clog2(ELEN / 8) + 1;

   logic [ELEN-1:0] simm;
   logic [ELEN-1:0] sum_w [NW];
   logic [ELEN-1:0] imm_w [NW];
   logic [NW-1:0]   eq_w;
   int              sel;

   assign simm = {{(ELEN-5){imm[4]}}, imm};
   assign sel  = (int'(sew) < NW) ? int'(sew) : 0;

   for (genvar g = 0; g < NW; g++) begin : g_width
      localparam int W = 8 << g;
      logic [W-1:0] s;
      assign s        = src[W-1:0] + simm[W-1:0];
      assign sum_w[g] = ELEN'(s);
      assign imm_w[g] = ELEN'(simm[W-1:0]);
      assign eq_w[g]  = (src[W-1:0] == simm[W-1:0]);
   end

   always_comb begin
      wr  = 1'b1;
      res = src;
      hit = 1'b0;
      case (op)
         OP_MERGE: res = active ? imm_w[sel] : src;
         OP_ADDI: begin
            wr  = active;
            res = sum_w[sel];
         end
         OP_CMPEQ: begin
            wr  = 1'b0;
            hit = eq_w[sel];
         end
         OP_CMPNE: begin
            wr  = 1'b0;
            hit = !eq_w[sel];
         end
         default: res = src;
      endcase
   end
endmodule

// File: rtl/vimm_exec.sv
module vimm_exec
   import vimm_pkg::*;
#(
   parameter int VLEN = 128,
   parameter int ELEN = 128,
   parameter int LVL  = $clog2(VLEN),
   parameter int CNTW = LVL + 1,
   parameter int EIW  = LVL - 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [2:0]      funct3,
   input  logic [5:0]      funct6,
   input  logic            vm,
   input  logic [4:0]      vd,
   input  logic [4:0]      rs1,
   input  logic [4:0]      vs2,
   input  logic [2:0]      sew,
   input  logic [CNTW-1:0] vl,
   input  logic [CNTW-1:0] vstart,
   input  logic [VLEN-1:0] v0_mask,
   output logic [4:0]      rf_rd_reg,
   output logic [EIW-1:0]  rf_rd_idx,
   output logic [2:0]      rf_sew,
   input  logic [ELEN-1:0] rf_rd_data,
   output logic            rf_wr_en,
   output logic [4:0]      rf_wr_reg,
   output logic [EIW-1:0]  rf_wr_idx,
   output logic [ELEN-1:0] rf_wr_data,
   output logic            mask_wr_en,
   output logic [4:0]      mask_wr_reg,
   output logic [VLEN-1:0] mask_wr_data,
   output logic            busy,
   output logic            done,
   output logic            err_unsup,
   output logic            err_illegal
);
   if (ELEN < 8 || (ELEN & (ELEN - 1)) != 0) begin : g_bad_elen
      $error("ELEN must be a power of two of at least 8");
   end
   if (VLEN < 16 || VLEN < ELEN || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two, at least 16 and at least ELEN");
   end

   vop_e            dec_op;
   logic            dec_unsup, dec_ill, dec_noop;
   logic [CNTW-1:0] dec_stop;

   vimm_decode #(.VLEN(VLEN), .ELEN(ELEN), .CNTW(CNTW)) u_dec (
      .f3(funct3), .f6(funct6), .vm(vm), .vd(vd), .rs1(rs1), .vs2(vs2),
      .sew(sew), .vl(vl), .vstart(vstart),
      .op(dec_op), .unsup(dec_unsup), .illegal(dec_ill), .noop(dec_noop),
      .stop(dec_stop)
   );

   logic            run_q, done_q, eu_q, ei_q, vm_q;
   vop_e            op_q;
   logic [CNTW-1:0] idx_q, stop_q;
   logic [4:0]      vd_q, rs1_q, vs2_q;
   logic [2:0]      sew_q;
   logic [VLEN-1:0] acc_q;

   logic [CNTW-1:0] epr_cur;
   logic [4:0]      grp_off;
   logic            in_range, is_cmp, active;
   logic            alu_wr, alu_hit;
   logic [ELEN-1:0] alu_res;

   assign epr_cur  = CNTW'(VLEN >> (3 + int'(sew_q)));
   assign grp_off  = 5'(idx_q >> (LVL - 3 - int'(sew_q)));
   assign in_range = idx_q < stop_q;
   assign is_cmp   = (op_q == OP_CMPEQ) || (op_q == OP_CMPNE);
   assign active   = vm_q || v0_mask[idx_q[LVL-1:0]];

   vimm_alu #(.ELEN(ELEN)) u_alu (
      .op(op_q), .sew(sew_q), .active(active), .src(rf_rd_data), .imm(rs1_q),
      .wr(alu_wr), .res(alu_res), .hit(alu_hit)
   );

   always_comb begin
      case (op_q)
         OP_VMOVE: rf_rd_reg = rs1_q;
         OP_WHOLE: rf_rd_reg = vs2_q + grp_off;
         default:  rf_rd_reg = vs2_q;
      endcase
   end

   assign rf_rd_idx    = EIW'(idx_q & (epr_cur - 1'b1));
   assign rf_wr_idx    = rf_rd_idx;
   assign rf_sew       = sew_q;
   assign rf_wr_reg    = (op_q == OP_WHOLE) ? vd_q + grp_off : vd_q;
   assign rf_wr_data   = alu_res;
   assign rf_wr_en     = run_q && in_range && alu_wr;
   assign mask_wr_en   = run_q && !in_range && is_cmp;
   assign mask_wr_reg  = vd_q;
   assign mask_wr_data = acc_q;
   assign busy         = run_q;
   assign done         = done_q;
   assign err_unsup    = eu_q;
   assign err_illegal  = ei_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         eu_q   <= 1'b0;
         ei_q   <= 1'b0;
         vm_q   <= 1'b1;
         op_q   <= OP_VMOVE;
         idx_q  <= '0;
         stop_q <= '0;
         vd_q   <= '0;
         rs1_q  <= '0;
         vs2_q  <= '0;
         sew_q  <= '0;
         acc_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (start) begin
               op_q   <= dec_op;
               vm_q   <= vm;
               vd_q   <= vd;
               rs1_q  <= rs1;
               vs2_q  <= vs2;
               sew_q  <= sew;
               idx_q  <= vstart;
               stop_q <= dec_stop;
               acc_q  <= '0;
               eu_q   <= dec_unsup;
               ei_q   <= dec_ill;
               if (dec_unsup || dec_ill || dec_noop) done_q <= 1'b1;
               else                                  run_q  <= 1'b1;
            end
         end else if (in_range) begin
            idx_q <= idx_q + 1'b1;
            if (is_cmp && alu_hit) acc_q[idx_q[LVL-1:0]] <= 1'b1;
         end else begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/vimm_exec_chk.sv
module vimm_exec_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic rf_wr_en,
   input logic mask_wr_en,
   input logic err_unsup,
   input logic err_illegal
);
   // R10: done only once the operation has left the busy state
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: no register file write outside an operation in progress
   a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_en || mask_wr_en) |-> busy);

   // R2: the whole mask write ends the compare
   a_r2_mask_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> done);

   // R10: an operation begins only from a start pulse
   a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9: error flags appear together with done
   a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_unsup) || $rose(err_illegal)) |-> done);
endmodule

bind vimm_exec vimm_exec_chk u_chk (.*);

// File: tb/vimm_exec_test.sv
module vimm_exec_test;
   localparam int CLK_PERIOD = 10;
   localparam int VL  = 128;
   localparam int EL  = 128;
   localparam int CW  = 8;
   localparam int EIW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    funct3 = '0;
   logic [5:0]    funct6 = '0;
   logic          vm = 1'b1;
   logic [4:0]    vd = '0, rs1 = '0, vs2 = '0;
   logic [2:0]    sew = '0;
   logic [CW-1:0] vl = '0, vstart = '0;
   logic [VL-1:0] v0_mask;
   logic [4:0]    rf_rd_reg, rf_wr_reg, mask_wr_reg;
   logic [EIW-1:0] rf_rd_idx, rf_wr_idx;
   logic [2:0]    rf_sew;
   logic [EL-1:0] rf_rd_data, rf_wr_data;
   logic [VL-1:0] mask_wr_data;
   logic          rf_wr_en, mask_wr_en, busy, done, err_unsup, err_illegal;

   logic [127:0] vrf    [32];
   logic [127:0] exp_rf [32];
   int nchk = 0;
   int nerr = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vimm_exec #(.VLEN(VL), .ELEN(EL)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .funct3(funct3), .funct6(funct6),
      .vm(vm), .vd(vd), .rs1(rs1), .vs2(vs2), .sew(sew), .vl(vl), .vstart(vstart),
      .v0_mask(v0_mask), .rf_rd_reg(rf_rd_reg), .rf_rd_idx(rf_rd_idx),
      .rf_sew(rf_sew), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
      .rf_wr_reg(rf_wr_reg), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .mask_wr_en(mask_wr_en), .mask_wr_reg(mask_wr_reg),
      .mask_wr_data(mask_wr_data), .busy(busy), .done(done),
      .err_unsup(err_unsup), .err_illegal(err_illegal)
   );

   function automatic logic [127:0] emask(int w);
      return (w >= 128) ? '1 : ((128'(1) << w) - 128'(1));
   endfunction

   function automatic logic [127:0] eget(logic [127:0] r, int i, int w);
      return (r >> (i * w)) & emask(w);
   endfunction

   function automatic logic [127:0] eput(logic [127:0] r, int i, int w, logic [127:0] v);
      return (r & ~(emask(w) << (i * w))) | ((v & emask(w)) << (i * w));
   endfunction

   // register file model seen by the block
   assign v0_mask    = vrf[0];
   assign rf_rd_data = eget(vrf[rf_rd_reg], int'(rf_rd_idx), 8 << rf_sew);

   always @(posedge clk) begin
      if (rf_wr_en)
         vrf[rf_wr_reg] <= eput(vrf[rf_wr_reg], int'(rf_wr_idx), 8 << rf_sew, rf_wr_data);
      if (mask_wr_en) vrf[mask_wr_reg] <= mask_wr_data;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic set_reg(input int r, input logic [127:0] v);
      vrf[r]    = v;
      exp_rf[r] = v;
   endtask

   task automatic run_op(input string req, input logic [2:0] f3, input logic [5:0] f6,
                         input logic vmi, input int vdi, input int rs1i, input int vs2i,
                         input int sewi, input int vli, input int vsti,
                         input bit xu, input bit xi, input bit poke);
      int w = 8 << sewi;
      int epr = 128 / w;
      int stp = vli;
      int exp_busy;
      int nb = 0;
      int cyc = 0;
      int bad = 0;
      logic [4:0] i5 = 5'(rs1i);
      logic [127:0] simm = {{123{i5[4]}}, i5};
      logic [127:0] m = '0;
      logic [127:0] v0 = exp_rf[0];
      bit whole = (f3 == 3'b011) && (f6 == 6'b100111);
      bit noop = whole && vmi && (vdi == vs2i) && !xi && !xu;
      if (whole) stp = (rs1i + 1) * epr;
      if (!xu && !xi && !noop) begin
         if (f3 == 3'b000) begin
            for (int i = vsti; i < vli; i++)
               exp_rf[vdi] = eput(exp_rf[vdi], i, w, eget(exp_rf[rs1i], i, w));
         end else if (f6 == 6'b011000 || f6 == 6'b011001) begin
            for (int i = vsti; i < vli; i++)
               if ((eget(exp_rf[vs2i], i, w) == (simm & emask(w))) == (f6 == 6'b011000))
                  m[i] = 1'b1;
            exp_rf[vdi] = m;
         end else if (f6 == 6'b010111) begin
            for (int i = vsti; i < vli; i++)
               exp_rf[vdi] = eput(exp_rf[vdi], i, w,
                                  (vmi || v0[i]) ? simm : eget(exp_rf[vs2i], i, w));
         end else if (f6 == 6'b000000) begin
            for (int i = vsti; i < vli; i++)
               if (vmi || v0[i])
                  exp_rf[vdi] = eput(exp_rf[vdi], i, w, eget(exp_rf[vs2i], i, w) + simm);
         end else begin
            for (int i = vsti; i < stp; i++)
               exp_rf[vdi + i / epr] = eput(exp_rf[vdi + i / epr], i % epr, w,
                                            eget(exp_rf[vs2i + i / epr], i % epr, w));
         end
      end
      exp_busy = (xu || xi || noop) ? 0 : ((stp > vsti) ? stp - vsti : 0) + 1;

      @(negedge clk);
      funct3 = f3; funct6 = f6; vm = vmi; vd = 5'(vdi); rs1 = 5'(rs1i); vs2 = 5'(vs2i);
      sew = 3'(sewi); vl = CW'(vli); vstart = CW'(vsti); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         funct3 = 3'b100;
         start  = 1'b1;
      end
      while (!done && cyc < 2000) begin
         if (busy) nb++;
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      chk(done, req, "done seen", 128'(done), 128'(1));
      chk(err_unsup == xu && err_illegal == xi, req, "error flags {unsup,illegal}",
          {err_unsup, err_illegal}, {xu, xi});
      chk(nb == exp_busy, req, "busy cycles", 128'(nb), 128'(exp_busy));
      for (int r = 0; r < 32; r++) begin
         if (vrf[r] !== exp_rf[r]) begin
            if (bad == 0) chk(1'b0, req, $sformatf("register v%0d", r), vrf[r], exp_rf[r]);
            bad++;
         end
      end
      if (bad == 0) chk(1'b1, req, "register file", '0, '0);
      @(negedge clk);
      chk(!done, req, "done single pulse", 128'(done), 128'(0));
   endtask

   initial begin
      for (int r = 0; r < 32; r++)
         set_reg(r, {4{32'(r) * 32'h01030507 ^ 32'h9e3779b9}});
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy && !done && !err_unsup && !err_illegal, "R11", "outputs in reset",
          {busy, done, err_unsup, err_illegal}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R11", "outputs after reset", {busy, done}, '0);

      // R1: element move, with a start pulse during the run (R10 ignored)
      run_op("R1 R10", 3'b000, 6'b010111, 1'b1, 5, 6, 0, 2, 4, 1, 0, 0, 1);
      run_op("R1", 3'b000, 6'b010111, 1'b0, 5, 6, 0, 2, 4, 0, 0, 1, 0);
      // R2 / R3: compares against sign-extended immediate
      set_reg(7, 128'h00FD_00FD_FD00_1111_FDFD_0000_00FD_22FD);
      run_op("R2", 3'b011, 6'b011000, 1'b0, 8, 5'b11101, 7, 0, 16, 2, 0, 0, 0);
      run_op("R3", 3'b011, 6'b011001, 1'b1, 8, 0, 7, 1, 8, 0, 0, 0, 0);
      run_op("R2 R10", 3'b011, 6'b011000, 1'b1, 9, 5'b11101, 7, 0, 3, 5, 0, 0, 0);
      // R4: merge under v0
      set_reg(0, 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_69A5);
      run_op("R4", 3'b011, 6'b010111, 1'b0, 9, 7, 10, 1, 8, 1, 0, 0, 0);
      run_op("R4", 3'b011, 6'b010111, 1'b1, 11, 5'b10001, 10, 2, 4, 0, 0, 0, 0);
      run_op("R4", 3'b011, 6'b010111, 1'b0, 0, 7, 10, 1, 8, 0, 0, 1, 0);
      // R5: add with wrap-around at several widths
      run_op("R5", 3'b011, 6'b000000, 1'b0, 11, 5'b11111, 7, 0, 16, 0, 0, 0, 0);
      set_reg(13, '1);
      run_op("R5", 3'b011, 6'b000000, 1'b1, 3, 1, 13, 3, 2, 0, 0, 0, 0);
      run_op("R5 R6", 3'b011, 6'b000000, 1'b1, 4, 5'b10000, 4, 4, 1, 0, 0, 0, 0);
      run_op("R5", 3'b011, 6'b000000, 1'b0, 0, 1, 4, 0, 4, 0, 0, 1, 0);
      // R6: width code and length limits
      run_op("R6", 3'b011, 6'b000000, 1'b1, 4, 1, 4, 5, 1, 0, 0, 1, 0);
      run_op("R6", 3'b011, 6'b000000, 1'b1, 4, 1, 4, 2, 5, 0, 0, 1, 0);
      // R7: whole-group copy
      run_op("R7", 3'b011, 6'b100111, 1'b1, 16, 1, 20, 2, 0, 0, 0, 0, 0);
      run_op("R7", 3'b011, 6'b100111, 1'b1, 24, 3, 16, 3, 0, 3, 0, 0, 0);
      run_op("R7", 3'b011, 6'b100111, 1'b1, 24, 2, 16, 2, 0, 0, 0, 1, 0);
      run_op("R7", 3'b011, 6'b100111, 1'b1, 24, 0, 16, 2, 0, 4, 0, 1, 0);
      // R8: copy onto itself
      run_op("R8", 3'b011, 6'b100111, 1'b1, 16, 1, 16, 2, 0, 0, 0, 0, 0);
      // R9: unsupported codes
      run_op("R9", 3'b011, 6'b000001, 1'b1, 5, 1, 6, 0, 4, 0, 1, 0, 0);
      run_op("R9", 3'b011, 6'b100111, 1'b0, 5, 1, 6, 0, 4, 0, 1, 0, 0);
      run_op("R9", 3'b100, 6'b010111, 1'b1, 5, 1, 6, 0, 4, 0, 1, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule